// File: doc/BRIEF.md
# Wrapping Line-Burst Read Controller

This block is a bus master that fills one 16-byte cache line by reading four 32-bit longwords from a synchronous external bus. A requester presents a longword-aligned address together with a request strobe. Address bits [3:2] pick the longword that is read first. The controller then reads the rest of the line in wrap-around order.

On the bus side the controller drives these outputs:

- a one-clock start pulse;
- a busy indication that lasts for the whole transfer;
- a combined strobe and chip-select pair that frames the data beats;
- the address.

It accepts a beat only on a clock where the slave's acknowledge is sampled high. Timing follows a 2-1-1-1 pattern when the slave adds no wait states.

Each accepted longword is returned on a registered read port with its 2-bit line offset. A one-clock done pulse marks the end of the burst. A mode input, latched with each request, selects how the address is driven:

- In held-address mode the address stays fixed for the whole burst.
- In stepping-address mode the address follows the longword currently being read.

Top module: `line_burst_reader`

## Requirements
- R1: While reset is high, and on the first clock after it, start, busy, strobe, select, read-valid and done are all low and the address output is zero.
- R2: A request that is sampled while the controller is idle produces a start pulse in the next cycle, lasting exactly one cycle. Busy rises in that same cycle.
- R3: Strobe and select rise in the cycle after the start pulse and stay high together until the cycle in which the fourth acknowledge is sampled, inclusive. They are low at all other times.
- R4: The offset tag of beat k (k = 0..3) is (s + k) mod 4, where s is bits [3:2] of the request address. Starts at 0, 1, 2 and 3 therefore give byte orders 0-4-8-C, 4-8-C-0, 8-C-0-4 and C-0-4-8.
- R5: A data word is taken only on a clock where acknowledge is high and strobe is high. Without acknowledge the controller inserts wait states for as long as needed. An acknowledge during the start cycle or outside a burst is ignored.
- R6: With the mode input low at the request (held-address mode), the address output equals the request address with bits [1:0] cleared for every cycle in which busy is high, and is zero while idle.
- R7: With the mode input high at the request (stepping-address mode), the address output carries the line base with bits [3:2] equal to the offset of the beat currently awaiting acknowledge. After the last beat it holds that offset until busy falls, then returns to zero.
- R8: Read-valid is high for exactly one cycle after each taken beat. In that cycle the read data equals the bus data sampled with the acknowledge, and the offset tag is that beat's offset.
- R9: After the fourth acknowledge, busy stays high for two more cycles and then falls. Done is high for exactly the one cycle in which busy is first low again.
- R10: A request raised while busy is high is ignored and produces no start pulse. A request sampled in the cycle in which done is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Line fetch request, sampled while idle |
| req_addr_i | input | 32 | Request address; bits [3:2] select the first longword |
| req_step_addr_i | input | 1 | 1 selects stepping-address mode, 0 selects held-address mode; latched with the request |
| bus_ack_i | input | 1 | Transfer acknowledge from the slave |
| bus_data_i | input | 32 | Read data from the bus |
| bus_start_o | output | 1 | One-cycle transfer start pulse |
| bus_busy_o | output | 1 | Transfer in progress |
| bus_strobe_o | output | 1 | Address strobe for the data beats |
| bus_sel_o | output | 1 | Chip select for the data beats |
| bus_addr_o | output | 32 | Bus address |
| rd_valid_o | output | 1 | Returned longword valid |
| rd_data_o | output | 32 | Returned longword |
| rd_off_o | output | 2 | Line offset (longword index) of the returned word |
| done_o | output | 1 | One-cycle burst completion pulse |

## Verification
Two functions can fall in the same cycle:

- the done pulse that closes one burst;
- the acceptance of the next request.

A request is also routinely pending during the two trailing hold cycles, when it must be ignored.

The first stretch of stimulus holds the request high without pause and acknowledges every beat. This makes each burst end with a done cycle in which the next request is sampled. The run then moves to random requests, wait states and acknowledges that arrive in the start cycle. The behavioural model predicts the start pulse in the cycle after done. It also predicts its absence after a request sampled while busy. These predictions are compared with the outputs every clock, and those checks are tagged R10.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

  // Phases of one line fetch
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BEAT  = 2'd2,
    PH_HOLD  = 2'd3
  } lbr_phase_e;

  // Width of a counter that must reach n-1 (at least one bit)
  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lbr_sequencer.sv
module lbr_sequencer
  import lbr_pkg::*;
#(
  parameter int LINE_BEATS = 4,
  parameter int HOLD_CYC   = 2,   // must be >= 1
  localparam int OFF_W  = cnt_width(LINE_BEATS),
  localparam int HOLD_W = cnt_width(HOLD_CYC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             ack_i,
  output logic [OFF_W-1:0] beat_o,
  output logic             accept_o,
  output logic             take_o,
  output logic             last_o,
  output logic             end_o,
  output logic             start_o,
  output logic             busy_o,
  output logic             strobe_o,
  output logic             sel_o,
  output logic             done_o
);

  localparam logic [OFF_W-1:0]  LAST_BEAT = OFF_W'(LINE_BEATS - 1);
  localparam logic [HOLD_W-1:0] LAST_HOLD = HOLD_W'(HOLD_CYC - 1);

  lbr_phase_e        ph_q, ph_d;
  logic [OFF_W-1:0]  beat_q;
  logic [HOLD_W-1:0] hold_q;
  logic              start_q, busy_q, strobe_q, sel_q, done_q;

  always_comb begin
    accept_o = (ph_q == PH_IDLE) && req_i;
    take_o   = (ph_q == PH_BEAT) && ack_i;
    last_o   = take_o && (beat_q == LAST_BEAT);
    end_o    = (ph_q == PH_HOLD) && (hold_q == LAST_HOLD);
  end

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (accept_o) ph_d = PH_START;
      PH_START: ph_d = PH_BEAT;
      PH_BEAT:  if (last_o) ph_d = PH_HOLD;
      PH_HOLD:  if (end_o) ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= PH_IDLE;
      beat_q   <= '0;
      hold_q   <= '0;
      start_q  <= 1'b0;
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
      sel_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      start_q <= accept_o;
      done_q  <= end_o;
      if (accept_o)
        beat_q <= '0;
      else if (take_o && !last_o)
        beat_q <= beat_q + OFF_W'(1);
      if (last_o)
        hold_q <= '0;
      else if (ph_q == PH_HOLD)
        hold_q <= hold_q + HOLD_W'(1);
      if (accept_o)
        busy_q <= 1'b1;
      else if (end_o)
        busy_q <= 1'b0;
      if (ph_q == PH_START) begin
        strobe_q <= 1'b1;
        sel_q    <= 1'b1;
      end else if (last_o) begin
        strobe_q <= 1'b0;
        sel_q    <= 1'b0;
      end
    end
  end

  assign beat_o   = beat_q;
  assign start_o  = start_q;
  assign busy_o   = busy_q;
  assign strobe_o = strobe_q;
  assign sel_o    = sel_q;
  assign done_o   = done_q;

endmodule

// File: rtl/lbr_addr_gen.sv
module lbr_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_step_i,
  input  logic              take_i,
  input  logic              last_i,
  input  logic              end_i,
  input  logic [OFF_W-1:0]  beat_i,
  output logic [OFF_W-1:0]  beat_off_o,
  output logic              step_mode_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int LO = OFF_W + 2;   // first bit of the line base

  logic [ADDR_W-1:0] addr_q;
  logic [OFF_W-1:0]  start_off_q;
  logic              step_q;
  logic [OFF_W-1:0]  next_off;

  // Offset wraps naturally in OFF_W bits
  assign beat_off_o = start_off_q + beat_i;
  assign next_off   = start_off_q + beat_i + OFF_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q      <= '0;
      start_off_q <= '0;
      step_q      <= 1'b0;
    end else if (accept_i) begin
      addr_q      <= req_addr_i & ~ADDR_W'(3);
      start_off_q <= req_addr_i[LO-1:2];
      step_q      <= req_step_i;
    end else if (end_i) begin
      addr_q <= '0;
    end else if (take_i && !last_i && step_q) begin
      addr_q <= {addr_q[ADDR_W-1:LO], next_off, 2'b00};
    end
  end

  assign addr_o      = addr_q;
  assign step_mode_o = step_q;

endmodule

// File: rtl/lbr_capture.sv
module lbr_capture #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [OFF_W-1:0]  off_o
);

  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic [OFF_W-1:0]  off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      off_q   <= '0;
    end else begin
      valid_q <= take_i;
      if (take_i) begin
        data_q <= data_i;
        off_q  <= off_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign off_o   = off_q;

endmodule

// File: rtl/line_burst_reader.sv
module line_burst_reader
  import lbr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BEATS = 4,
  parameter int HOLD_CYC   = 2,
  localparam int OFF_W = cnt_width(LINE_BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_step_addr_i,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              bus_start_o,
  output logic              bus_busy_o,
  output logic              bus_strobe_o,
  output logic              bus_sel_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [OFF_W-1:0]  rd_off_o,
  output logic              done_o
);

  logic [OFF_W-1:0] beat_idx;
  logic [OFF_W-1:0] beat_off;
  logic             accept, take, last, burst_end;
  logic             step_mode;

  lbr_sequencer #(
    .LINE_BEATS(LINE_BEATS),
    .HOLD_CYC  (HOLD_CYC)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .ack_i   (bus_ack_i),
    .beat_o  (beat_idx),
    .accept_o(accept),
    .take_o  (take),
    .last_o  (last),
    .end_o   (burst_end),
    .start_o (bus_start_o),
    .busy_o  (bus_busy_o),
    .strobe_o(bus_strobe_o),
    .sel_o   (bus_sel_o),
    .done_o  (done_o)
  );

  lbr_addr_gen #(
    .ADDR_W(ADDR_W),
    .OFF_W (OFF_W)
  ) u_addr (
    .clk        (clk),
    .rst        (rst),
    .accept_i   (accept),
    .req_addr_i (req_addr_i),
    .req_step_i (req_step_addr_i),
    .take_i     (take),
    .last_i     (last),
    .end_i      (burst_end),
    .beat_i     (beat_idx),
    .beat_off_o (beat_off),
    .step_mode_o(step_mode),
    .addr_o     (bus_addr_o)
  );

  lbr_capture #(
    .DATA_W(DATA_W),
    .OFF_W (OFF_W)
  ) u_cap (
    .clk    (clk),
    .rst    (rst),
    .take_i (take),
    .data_i (bus_data_i),
    .off_i  (beat_off),
    .valid_o(rd_valid_o),
    .data_o (rd_data_o),
    .off_o  (rd_off_o)
  );

endmodule

// File: rtl/lbr_checker.sv
module lbr_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              ack,
  input logic              start,
  input logic              busy,
  input logic              strobe,
  input logic              sel,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_valid,
  input logic              done,
  input logic              step_mode
);

  // R1: reset clears every control output
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!start && !busy && !strobe && !sel && !rd_valid && !done && addr == '0));

  // R2: start lasts one cycle and comes with busy
  p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    start |-> busy);

  // R3: strobe and select follow the start pulse, move together, stay inside busy
  p_strobe_follows_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> (strobe && sel));
  p_strobe_sel_pair_r3: assert property (@(posedge clk) disable iff (rst)
    strobe == sel);
  p_strobe_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
    strobe |-> busy);

  // R5: returned data implies an acknowledge during the strobe window
  p_take_needs_ack_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(ack) && $past(strobe)));

  // R6: held-address mode keeps the address fixed while busy
  p_held_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !step_mode) |-> $stable(addr));

  // R9: done marks the fall of busy and lasts one cycle
  p_done_at_fall_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: no new start while a burst occupies the bus
  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> !start);

endmodule

bind line_burst_reader lbr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ack      (bus_ack_i),
  .start    (bus_start_o),
  .busy     (bus_busy_o),
  .strobe   (bus_strobe_o),
  .sel      (bus_sel_o),
  .addr     (bus_addr_o),
  .rd_valid (rd_valid_o),
  .done     (done_o),
  .step_mode(step_mode)
);

// File: tb/line_burst_reader_test.sv
`timescale 1ns/1ps
module line_burst_reader_test;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int RUN_CYC = 4000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_step = 1'b0;
  logic          ack = 1'b0;
  logic [DW-1:0] bdata = '0;
  logic          start, busy, strobe, sel, rvalid, done;
  logic [AW-1:0] addr;
  logic [DW-1:0] rdata;
  logic [1:0]    roff;

  always #2 clk = ~clk;

  line_burst_reader uut (
    .clk(clk), .rst(rst), .req_i(req), .req_addr_i(req_addr),
    .req_step_addr_i(req_step), .bus_ack_i(ack), .bus_data_i(bdata),
    .bus_start_o(start), .bus_busy_o(busy), .bus_strobe_o(strobe),
    .bus_sel_o(sel), .bus_addr_o(addr), .rd_valid_o(rvalid),
    .rd_data_o(rdata), .rd_off_o(roff), .done_o(done)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference model: phase 0 idle, 1 start, 2 beats, 3 trailing hold
  int      m_ph = 0, m_beat = 0, m_hold = 0, m_off0 = 0, accepted = 0;
  logic [AW-1:0] m_line = '0;
  bit      m_step = 0;
  bit      e_start = 0, e_busy = 0, e_strobe = 0, e_valid = 0, e_done = 0;
  logic [AW-1:0] e_addr = '0;
  logic [DW-1:0] e_data = '0;
  int      e_off = 0;
  bit      tag_r10 = 0;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(tag_r10 ? "R10" : "R2", "start", 64'(start), 64'(e_start));
    chk(e_done ? "R9" : "R2", "busy", 64'(busy), 64'(e_busy));
    chk("R3", "strobe", 64'(strobe), 64'(e_strobe));
    chk("R3", "select", 64'(sel), 64'(e_strobe));
    chk(m_step ? "R7" : "R6", "address", 64'(addr), 64'(e_addr));
    chk("R8", "read valid", 64'(rvalid), 64'(e_valid));
    chk("R9", "done", 64'(done), 64'(e_done));
    if (e_valid) begin
      chk("R5", "read data", 64'(rdata), 64'(e_data));
      chk("R4", "offset tag", 64'(roff), 64'(e_off));
    end
  endtask

  task automatic drive(input int n);
    bdata = $urandom;
    if (n < 120) begin
      // Request held high, every beat acknowledged: back-to-back bursts
      req      = 1'b1;
      ack      = 1'b1;
      req_addr = {$urandom, 2'b00};
      req_addr[3:2] = 2'(accepted);
      req_step = accepted[2];
    end else begin
      req      = ($urandom % 10) < 3;
      ack      = ($urandom % 10) < 6;
      req_addr = $urandom;
      req_step = $urandom % 2;
    end
  endtask

  task automatic step_model();
    tag_r10 = req && (m_ph != 0 || e_done);
    e_valid = 0;
    e_start = 0;
    e_done  = 0;
    case (m_ph)
      0: if (req) begin
           m_ph = 1; m_beat = 0; accepted++;
           m_line = req_addr & ~32'hF;
           m_off0 = int'(req_addr[3:2]);
           m_step = req_step;
           e_start = 1; e_busy = 1;
           e_addr = req_addr & ~32'h3;
         end
      1: begin m_ph = 2; e_strobe = 1; end
      2: if (ack) begin
           e_valid = 1; e_data = bdata; e_off = (m_off0 + m_beat) % 4;
           if (m_beat == 3) begin
             m_ph = 3; m_hold = 0; e_strobe = 0;
           end else begin
             m_beat++;
             if (m_step) e_addr = m_line | 32'(((m_off0 + m_beat) % 4) * 4);
           end
         end
      default: if (m_hold == 1) begin
                 m_ph = 0; e_busy = 0; e_done = 1; e_addr = '0;
               end else m_hold++;
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "start in reset", 64'(start), 64'(0));
    chk("R1", "busy in reset", 64'(busy), 64'(0));
    chk("R1", "strobe in reset", 64'(strobe), 64'(0));
    chk("R1", "valid in reset", 64'(rvalid), 64'(0));
    chk("R1", "address in reset", 64'(addr), 64'(0));
    rst = 1'b0;
    for (int n = 0; n < RUN_CYC; n++) begin
      @(negedge clk);
      compare_all();
      drive(n);
      step_model();
    end
    if (accepted < 40) begin
      fails++;
      $display("FAIL R2 too few bursts actual=%0d expected>=40", accepted);
    end
    checks++;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule